// File: doc/BRIEF.md
# Trigger Delay Sequencer

This controller times the interval between an external trigger and the moment a sample is taken. The interval has two parts. A coarse part is counted in whole clock periods. A fine part is measured by an external interpolating ramp, which a comparator watches.

The sequence runs as follows. The trigger starts the ramp. The ramp stops on the next clock phase, and the coarse counter then runs for the programmed number of periods. When the count ends, the ramp starts again. It stops for good when the comparator reports that the sample was taken. The ramp, the fine-delay DAC and the comparator are analog parts outside the block.

Software or a system controller pulses the arm input and presents the coarse count on that same cycle. The block then waits for one trigger, runs the sequence once, and parks in a done state until it is armed again. A sticky error flag records any comparator pulse that arrives outside the final ramp phase.

Top module: `trig_delay_seq`

## Requirements
- R1: After reset every output is low and the block is idle. A trigger edge seen before the first arm pulse starts nothing.
- R2: An arm pulse takes effect from any state. It loads the coarse count, enters the armed state and clears the error flag.
- R3: In the armed state, the first rising trigger edge is accepted. It passes through a two-flop synchronizer, so ramp_en_o, cnt_en_o, v_hold_o and trig_stb_o all rise on the third clock edge after the trigger goes high. trig_stb_o is high for exactly one cycle.
- R4: One cycle after acceptance, ramp_en_o falls and clk_gate_o rises. clk_gate_o and cnt_en_o then stay high for exactly N cycles, where N is the loaded coarse count. ramp_en_o and clk_gate_o are never high together.
- R5: After the N count cycles, ramp_en_o rises again and stays high until the sample input is seen. If N is 0, the count phase is skipped and the second ramp follows the accept cycle directly.
- R6: A sample pulse during the second ramp moves the block to done on the next clock edge. In done, ramp_en_o is low, done_o is high and v_hold_o stays high.
- R7: Done holds until the next arm pulse. Further trigger edges in done cause no output change and no strobe.
- R8: A sample pulse in any state other than the second ramp leaves the sequence unchanged and sets err_o. err_o stays set until an arm pulse.
- R9: v_hold_o is high from the accept cycle through done, and low in idle and armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | One-cycle arm/re-arm strobe |
| trig_i | input | 1 | Asynchronous trigger |
| coarse_cnt_i | input | 8 | Coarse delay in clock periods, sampled at arm |
| sample_taken_i | input | 1 | Comparator "sample taken" pulse |
| ramp_en_o | output | 1 | Interpolating ramp enable |
| cnt_en_o | output | 1 | Coarse counter enable |
| v_hold_o | output | 1 | Voltage hold |
| clk_gate_o | output | 1 | Clock gate enable feeding the coarse counter |
| trig_stb_o | output | 1 | One-cycle strobe marking trigger acceptance |
| done_o | output | 1 | Sequence complete |
| err_o | output | 1 | Sticky flag for a sample pulse outside the second ramp |

## Verification
Take a trigger that rises just after clock edge 0. The accept outputs are due at edge 3. The count phase covers edges 4 through 3+N, the second ramp starts at edge 4+N, and done follows the first edge that sees the sample input.

The error flag and the arm state change one edge after their strobe. Every input is driven on a falling edge and every output is sampled on a falling edge. Each check therefore falls in the half cycle after the edge that made the change, and the checks walk the sequence cycle by cycle rather than waiting for a settled state.

// File: rtl/tds_pkg.sv
package tds_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARMED = 3'd1,
    ST_RAMP1 = 3'd2,
    ST_COUNT = 3'd3,
    ST_RAMP2 = 3'd4,
    ST_DONE  = 3'd5
  } tds_state_e;
endpackage

// File: rtl/tds_trig_sync.sv
module tds_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], trig_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  p_rise_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/tds_coarse_cnt.sv
module tds_coarse_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  input  logic             dec_i,
  output logic             zero_o,
  output logic             one_o
);
  logic [CNT_W-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rem_q <= '0;
    else if (load_i) rem_q <= val_i;
    else if (dec_i)  rem_q <= rem_q - 1'b1;
  end

  assign zero_o = (rem_q == '0);
  assign one_o  = (rem_q == CNT_W'(1));

  p_no_underflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> !zero_o);
endmodule

// File: rtl/tds_fsm.sv
module tds_fsm
  import tds_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic rise_i,
  input  logic sample_i,
  input  logic cnt_zero_i,
  input  logic cnt_one_i,
  output logic dec_o,
  output logic ramp_en_o,
  output logic cnt_en_o,
  output logic v_hold_o,
  output logic clk_gate_o,
  output logic trig_stb_o,
  output logic done_o,
  output logic err_o
);
  tds_state_e state_q, state_d;
  logic       err_q;

  always_comb begin
    state_d = state_q;
    if (arm_i) state_d = ST_ARMED;
    else begin
      unique case (state_q)
        ST_ARMED: if (rise_i)     state_d = ST_RAMP1;
        ST_RAMP1: state_d = cnt_zero_i ? ST_RAMP2 : ST_COUNT;
        ST_COUNT: if (cnt_one_i)  state_d = ST_RAMP2;
        ST_RAMP2: if (sample_i)   state_d = ST_DONE;
        default:  state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= (err_q & ~arm_i) | (sample_i & (state_q != ST_RAMP2));
    end
  end

  assign ramp_en_o  = (state_q == ST_RAMP1) | (state_q == ST_RAMP2);
  assign clk_gate_o = (state_q == ST_COUNT);
  assign cnt_en_o   = (state_q == ST_RAMP1) | (state_q == ST_COUNT);
  assign v_hold_o   = (state_q != ST_IDLE) & (state_q != ST_ARMED);
  assign trig_stb_o = (state_q == ST_RAMP1);
  assign done_o     = (state_q == ST_DONE);
  assign dec_o      = clk_gate_o & ~arm_i;
  assign err_o      = err_q;

  p_accept_from_armed_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_stb_o |-> $past(state_q) == ST_ARMED);
  p_ramp1_once_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_stb_o |=> !trig_stb_o);
  p_gate_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ramp_en_o && clk_gate_o));
  p_tc_restart_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_gate_o && cnt_one_i && !arm_i) |=> (ramp_en_o && !clk_gate_o));
  p_done_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !arm_i) |=> done_o);
  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !arm_i) |=> err_o);
  p_hold_span_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_hold_o && !arm_i) |=> v_hold_o);
endmodule

// File: rtl/trig_delay_seq.sv
module trig_delay_seq #(
  parameter int CNT_W     = 8,
  parameter int SYNC_STGS = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             trig_i,
  input  logic [CNT_W-1:0] coarse_cnt_i,
  input  logic             sample_taken_i,
  output logic             ramp_en_o,
  output logic             cnt_en_o,
  output logic             v_hold_o,
  output logic             clk_gate_o,
  output logic             trig_stb_o,
  output logic             done_o,
  output logic             err_o
);
  logic rise, cnt_zero, cnt_one, dec;

  tds_trig_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .trig_i(trig_i),
    .rise_o(rise)
  );

  tds_coarse_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(arm_i),
    .val_i (coarse_cnt_i),
    .dec_i (dec),
    .zero_o(cnt_zero),
    .one_o (cnt_one)
  );

  tds_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .arm_i     (arm_i),
    .rise_i    (rise),
    .sample_i  (sample_taken_i),
    .cnt_zero_i(cnt_zero),
    .cnt_one_i (cnt_one),
    .dec_o     (dec),
    .ramp_en_o (ramp_en_o),
    .cnt_en_o  (cnt_en_o),
    .v_hold_o  (v_hold_o),
    .clk_gate_o(clk_gate_o),
    .trig_stb_o(trig_stb_o),
    .done_o    (done_o),
    .err_o     (err_o)
  );
endmodule

// File: tb/trig_delay_seq_test.sv
`timescale 1ns/1ps
module trig_delay_seq_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic arm = 1'b0, trig = 1'b0, smp = 1'b0;
  logic [7:0] cnt = '0;
  logic ramp, cen, hold, gate, stb, done, err;
  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  trig_delay_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .trig_i(trig),
    .coarse_cnt_i(cnt), .sample_taken_i(smp),
    .ramp_en_o(ramp), .cnt_en_o(cen), .v_hold_o(hold), .clk_gate_o(gate),
    .trig_stb_o(stb), .done_o(done), .err_o(err)
  );

  // {ramp, cnt_en, hold, gate, stb, done, err}
  task automatic chk(string req, logic [6:0] exp);
    logic [6:0] act;
    act = {ramp, cen, hold, gate, stb, done, err};
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%b exp=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_arm(logic [7:0] n);
    @(negedge clk); arm = 1'b1; cnt = n;
    @(negedge clk); arm = 1'b0;
  endtask

  // coarse count, extra ramp2 cycles before sample
  localparam logic [15:0] VEC [5] = '{
    {8'd0, 8'd0}, {8'd1, 8'd2}, {8'd3, 8'd0}, {8'd7, 8'd1}, {8'd255, 8'd3}
  };

  task automatic run_seq(logic [7:0] n, logic [7:0] d);
    do_arm(n);
    chk("R2 armed", 7'b0000000);
    trig = 1'b1;
    @(negedge clk);
    @(negedge clk); chk("R3 sync latency", 7'b0000000);
    @(negedge clk); chk("R3 accept", 7'b1110100);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); chk("R4 count", 7'b0111000);
    end
    @(negedge clk); chk("R5 ramp2", 7'b1010000);
    for (int i = 0; i < d; i++) begin
      @(negedge clk); chk("R5 ramp2 hold", 7'b1010000);
    end
    smp = 1'b1;
    @(negedge clk); smp = 1'b0; chk("R6 done", 7'b0010010);
    trig = 1'b0;
  endtask

  initial begin
    #100000;
    if (!finished) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: act=timeout exp=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 reset", 7'b0000000);
    rst_n = 1'b1;
    // R1: trigger before any arm is ignored
    trig = 1'b1;
    repeat (4) begin
      @(negedge clk); chk("R1 no arm", 7'b0000000);
    end
    trig = 1'b0;
    @(negedge clk);

    for (int v = 0; v < 5; v++) run_seq(VEC[v][15:8], VEC[v][7:0]);

    // R7: retrigger in done ignored
    @(negedge clk); trig = 1'b1;
    repeat (5) begin
      @(negedge clk); chk("R7 retrig ignored", 7'b0010010);
    end
    trig = 1'b0;
    @(negedge clk);

    // R8: stray sample in armed, sequence unaffected, error sticky
    do_arm(8'd2);
    smp = 1'b1;
    @(negedge clk); smp = 1'b0; chk("R8 err set", 7'b0000001);
    repeat (2) begin
      @(negedge clk); chk("R8 err sticky", 7'b0000001);
    end
    // R8: sample during count ignored
    trig = 1'b1;
    repeat (3) @(negedge clk);
    chk("R3 accept w/ err", 7'b1110101);
    smp = 1'b1;
    @(negedge clk); smp = 1'b0; chk("R8 count ignores sample", 7'b0111001);
    @(negedge clk); chk("R8 count cont", 7'b0111001);
    @(negedge clk); chk("R5 ramp2 after 2", 7'b1010001);
    // R2: arm mid-ramp2 aborts and clears error
    arm = 1'b1; cnt = 8'd0;
    @(negedge clk); arm = 1'b0; chk("R2 rearm clears", 7'b0000000);
    trig = 1'b0;
    repeat (3) @(negedge clk);
    // R5 N=0 with R9 hold check
    trig = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 hold on accept", 7'b1110100);
    @(negedge clk); chk("R5 zero skip", 7'b1010000);
    smp = 1'b1;
    @(negedge clk); smp = 1'b0; chk("R6 done n0", 7'b0010010);
    smp = 1'b1;
    @(negedge clk); smp = 1'b0; chk("R8 sample in done", 7'b0010011);
    trig = 1'b0;

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule